// File: doc/BRIEF.md
# Integer Operate Execution Unit

This block is a 64-bit integer execute stage for operate-format instructions. Each instruction is a 32-bit word from one of two major opcode groups. One group covers add, subtract, scaled add/subtract and compares. The other covers bitwise logic and conditional moves. Operand A always comes from a register. Operand B comes either from a register or from an 8-bit literal carried in the word. Results go to a 32-entry register file held inside the unit. In that file the highest index is hardwired to zero.

A caller presents a word together with a one-cycle issue strobe. One clock later the unit shows the result, a write-enable, the destination index and an illegal-instruction flag. A write-enabled result is also written back into the internal register file, so the next instruction sees it. A separate load port lets the surrounding logic, or a testbench, preset any register.

Top module: `int_operate_unit`

## Requirements
- R1: Instruction fields are: major opcode [31:26], A register [25:21], B register [20:16], function [11:5], destination [4:0]. When bit 12 is 1, operand B is the literal in bits [20:13], zero-extended; when bit 12 is 0, operand B is the B register.
- R2: In opcode 0x10: ADDQ (0x20) gives A+B and SUBQ (0x29) gives A-B. S4ADDQ (0x22) and S8ADDQ (0x32) give 4A+B and 8A+B. S4SUBQ (0x2B) and S8SUBQ (0x3B) give 4A-B and 8A-B. ADDL (0x00) adds the low 32 bits of A and B and sign-extends the 32-bit sum to 64 bits.
- R3: In opcode 0x10, compares write 1 when true and 0 when false. The signed compares are CMPLT (0x4D, A<B) and CMPLE (0x6D, A<=B). The unsigned compares are CMPULT (0x1D, A<B) and CMPULE (0x3D, A<=B). CMPEQ (0x2D) tests equality.
- R4: In opcode 0x11: AND (0x00) gives A&B, BIS (0x20) gives A|B and XOR (0x40) gives A^B. BIC (0x08) gives A&~B, ORNOT (0x28) gives A|~B and EQV (0x48) gives A^~B.
- R5: In opcode 0x11, each conditional move writes operand B to the destination only when its test on A holds. Otherwise the write-enable stays low. The tests are: CMOVLBS (0x14) bit 0 set, CMOVLBC (0x16) bit 0 clear, CMOVEQ (0x24) A==0, CMOVNE (0x26) A!=0, CMOVLT (0x44) A<0, CMOVGE (0x46) A>=0, CMOVLE (0x64) A<=0, CMOVGT (0x66) A>0. All signed tests treat A as two's complement.
- R6: Register 31 always reads as zero. Any write to it, whether a result or a load, is discarded, and a result aimed at it has its write-enable low.
- R7: A function code not listed in R2 to R5 for its group raises the illegal flag, and so does any major opcode other than 0x10 or 0x11. An illegal instruction never has its write-enable high.
- R8: res_valid is high exactly one cycle after a cycle with issue_valid high. At that point res_rc holds the destination field of the issued word.
- R9: A write-enabled result updates the internal register file, and later instructions read the new value. If a load and a result write hit the same index in the same cycle, the result write takes effect.
- R10: After reset, res_valid, res_we and res_illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| load_en | input | 1 | Write load_data into the register file |
| load_idx | input | 5 | Register index for a load |
| load_data | input | XLEN | Value for a load |
| issue_valid | input | 1 | issue_instr holds an instruction this cycle |
| issue_instr | input | 32 | Operate-format instruction word |
| res_valid | output | 1 | A result from the previous cycle is present |
| res_we | output | 1 | The result is written to register res_rc |
| res_rc | output | 5 | Destination register index |
| res_data | output | XLEN | Computed result |
| res_illegal | output | 1 | The issued word had an unknown opcode or function |

## Verification
Two functions can fall in the same cycle: a load through the load port, and the write-back of an issued instruction. The bench drives a load and an issue that target the same register on one clock edge. It then reads that register back through a following add with a zero literal, and expects the computed result rather than the loaded value. Loads and result writes aimed at register 31 are also checked, by reading that register back as zero.

// File: rtl/int_operate_unit.sv
module int_operate_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [4:0]      load_idx,
  input  logic [XLEN-1:0] load_data,
  input  logic            issue_valid,
  input  logic [31:0]     issue_instr,
  output logic            res_valid,
  output logic            res_we,
  output logic [4:0]      res_rc,
  output logic [XLEN-1:0] res_data,
  output logic            res_illegal
);
  localparam int NREG = 32;
  localparam logic [4:0] ZREG = 5'd31;
  localparam logic [5:0] OP_ARITH = 6'h10;
  localparam logic [5:0] OP_LOGIC = 6'h11;

  logic [XLEN-1:0] rf [NREG];

  wire [5:0] opc = issue_instr[31:26];
  wire [4:0] ra  = issue_instr[25:21];
  wire [4:0] rb  = issue_instr[20:16];
  wire [6:0] fn  = issue_instr[11:5];
  wire [4:0] rc  = issue_instr[4:0];

  wire [XLEN-1:0] a = (ra == ZREG) ? '0 : rf[ra];
  wire [XLEN-1:0] b = issue_instr[12] ? XLEN'(issue_instr[20:13])
                                      : ((rb == ZREG) ? '0 : rf[rb]);
  wire [31:0] sum32 = a[31:0] + b[31:0];
  wire sa_neg  = a[XLEN-1];
  wire sa_zero = (a == '0);
  wire s_lt    = $signed(a) < $signed(b);
  wire u_lt    = a < b;
  wire eq      = (a == b);

  logic [XLEN-1:0] result;
  logic            ill;
  logic            cond;

  always_comb begin
    result = '0;
    ill    = 1'b0;
    cond   = 1'b1;
    unique case (opc)
      OP_ARITH:
        case (fn)
          7'h00: result = {{(XLEN-32){sum32[31]}}, sum32};
          7'h20: result = a + b;
          7'h22: result = (a << 2) + b;
          7'h32: result = (a << 3) + b;
          7'h29: result = a - b;
          7'h2B: result = (a << 2) - b;
          7'h3B: result = (a << 3) - b;
          7'h2D: result = XLEN'(eq);
          7'h1D: result = XLEN'(u_lt);
          7'h3D: result = XLEN'(u_lt | eq);
          7'h4D: result = XLEN'(s_lt);
          7'h6D: result = XLEN'(s_lt | eq);
          default: ill = 1'b1;
        endcase
      OP_LOGIC: begin
        result = b;
        case (fn)
          7'h00: result = a & b;
          7'h08: result = a & ~b;
          7'h20: result = a | b;
          7'h28: result = a | ~b;
          7'h40: result = a ^ b;
          7'h48: result = a ^ ~b;
          7'h14: cond = a[0];
          7'h16: cond = ~a[0];
          7'h24: cond = sa_zero;
          7'h26: cond = ~sa_zero;
          7'h44: cond = sa_neg;
          7'h46: cond = ~sa_neg;
          7'h64: cond = sa_neg | sa_zero;
          7'h66: cond = ~sa_neg & ~sa_zero;
          default: ill = 1'b1;
        endcase
      end
      default: ill = 1'b1;
    endcase
  end

  wire wr = issue_valid && !ill && cond && (rc != ZREG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_we      <= 1'b0;
      res_illegal <= 1'b0;
      res_rc      <= '0;
      res_data    <= '0;
    end else begin
      res_valid   <= issue_valid;
      res_we      <= wr;
      res_illegal <= issue_valid && ill;
      if (issue_valid) begin
        res_rc   <= rc;
        res_data <= result;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_en && load_idx != ZREG) rf[load_idx] <= load_data;
    if (wr) rf[rc] <= result;
  end
endmodule

module int_operate_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic [31:0]     issue_instr,
  input logic            res_valid,
  input logic            res_we,
  input logic [4:0]      res_rc,
  input logic [XLEN-1:0] res_data,
  input logic            res_illegal
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> res_valid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !res_valid); // R8
  AST_RC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> res_rc == $past(issue_instr[4:0])); // R8
  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_rc != 5'd31); // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> !res_we && res_valid); // R7
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_instr[31:27] != 5'b01000 |=> res_illegal); // R7
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_instr[31:26] == 6'h10 && issue_instr[7:5] == 3'b101
      && issue_instr[11:8] != 4'h0 |=> res_data <= 1); // R3
endmodule

bind int_operate_unit int_operate_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_int_operate_unit.sv
module tb_int_operate_unit;
  localparam int XLEN = 64;
  localparam int NV = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic [4:0] load_idx = '0;
  logic [XLEN-1:0] load_data = '0;
  logic issue_valid = 1'b0;
  logic [31:0] issue_instr = '0;
  logic res_valid, res_we, res_illegal;
  logic [4:0] res_rc;
  logic [XLEN-1:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  int_operate_unit #(.XLEN(XLEN)) dut (.*);

  function automatic logic [31:0] rr(input logic [5:0] op, input logic [6:0] fn,
                                     input logic [4:0] ra, input logic [4:0] rb);
    return {op, ra, rb, 3'b000, 1'b0, fn, 5'd0};
  endfunction

  function automatic logic [31:0] rl(input logic [5:0] op, input logic [6:0] fn,
                                     input logic [4:0] ra, input logic [7:0] lit);
    return {op, ra, lit, 1'b1, fn, 5'd0};
  endfunction

  function automatic logic [96:0] v(input logic [31:0] ins, input logic [63:0] d,
                                    input logic we);
    return {ins, d, we};
  endfunction

  // r1=7FFFFFFF r2=1 r3=-2 r4=0 r5=00FF00FF12345678
  localparam logic [96:0] VEC [NV] = '{
    v(rr(6'h10, 7'h00, 1, 2), 64'hFFFF_FFFF_8000_0000, 1), // R2 ADDL
    v(rr(6'h10, 7'h20, 1, 2), 64'h0000_0000_8000_0000, 1), // R2 ADDQ
    v(rl(6'h10, 7'h22, 2, 3), 64'd7, 1),                   // R1 R2 S4ADDQ lit
    v(rr(6'h10, 7'h29, 2, 3), 64'd3, 1),                   // R2 SUBQ
    v(rl(6'h10, 7'h3B, 2, 9), 64'hFFFF_FFFF_FFFF_FFFF, 1), // R2 S8SUBQ
    v(rr(6'h10, 7'h2B, 2, 2), 64'd3, 1),                   // R2 S4SUBQ
    v(rr(6'h10, 7'h32, 2, 2), 64'd9, 1),                   // R2 S8ADDQ
    v(rr(6'h10, 7'h1D, 2, 3), 64'd1, 1),                   // R3 CMPULT
    v(rr(6'h10, 7'h4D, 2, 3), 64'd0, 1),                   // R3 CMPLT
    v(rr(6'h10, 7'h6D, 3, 3), 64'd1, 1),                   // R3 CMPLE
    v(rl(6'h10, 7'h2D, 4, 0), 64'd1, 1),                   // R3 CMPEQ
    v(rr(6'h10, 7'h3D, 3, 2), 64'd0, 1),                   // R3 CMPULE
    v(rl(6'h11, 7'h00, 5, 8'hFF), 64'h78, 1),              // R4 AND lit
    v(rr(6'h11, 7'h08, 5, 3), 64'd0, 1),                   // R4 BIC
    v(rr(6'h11, 7'h20, 2, 3), 64'hFFFF_FFFF_FFFF_FFFF, 1), // R4 BIS
    v(rr(6'h11, 7'h28, 4, 3), 64'd1, 1),                   // R4 ORNOT
    v(rr(6'h11, 7'h40, 5, 5), 64'd0, 1),                   // R4 XOR
    v(rr(6'h11, 7'h48, 4, 4), 64'hFFFF_FFFF_FFFF_FFFF, 1), // R4 EQV
    v(rl(6'h11, 7'h14, 2, 5), 64'd5, 1),                   // R5 CMOVLBS
    v(rl(6'h11, 7'h16, 2, 5), 64'd0, 0),                   // R5 CMOVLBC
    v(rr(6'h11, 7'h24, 4, 5), 64'h00FF_00FF_1234_5678, 1), // R5 CMOVEQ
    v(rr(6'h11, 7'h26, 4, 5), 64'd0, 0),                   // R5 CMOVNE
    v(rl(6'h11, 7'h44, 3, 7), 64'd7, 1),                   // R5 CMOVLT
    v(rl(6'h11, 7'h46, 3, 7), 64'd0, 0),                   // R5 CMOVGE
    v(rl(6'h11, 7'h64, 4, 6), 64'd6, 1),                   // R5 CMOVLE
    v(rl(6'h11, 7'h66, 4, 6), 64'd0, 0),                   // R5 CMOVGT zero
    v(rl(6'h11, 7'h66, 2, 6), 64'd6, 1)                    // R5 CMOVGT pos
  };

  task automatic check(input bit ok, input string req, input logic [XLEN:0] act,
                       input logic [XLEN:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] idx, input logic [XLEN-1:0] d);
    @(negedge clk);
    load_en = 1'b1; load_idx = idx; load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic issue(input logic [31:0] ins);
    @(negedge clk);
    issue_valid = 1'b1; issue_instr = ins;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic we, input logic [XLEN-1:0] d);
    logic [XLEN:0] act, exp;
    act = {res_we, res_we ? res_data : '0};
    exp = {we, we ? d : '0};
    check(res_valid && !res_illegal && act == exp, req, act, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!res_valid && !res_we && !res_illegal, "R10",
          {62'd0, res_valid, res_we, res_illegal}, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 31; i++) load(5'(i), '0);
    load(5'd1, 64'h0000_0000_7FFF_FFFF);
    load(5'd2, 64'd1);
    load(5'd3, 64'hFFFF_FFFF_FFFF_FFFE);
    load(5'd5, 64'h00FF_00FF_1234_5678);

    for (int i = 0; i < NV; i++) begin
      logic [4:0] rc;
      rc = 5'(8 + i % 20);
      issue(VEC[i][96:65] | {27'd0, rc});
      expect_res($sformatf("R1-vector%0d", i), VEC[i][0], VEC[i][64:1]);
      check(res_rc == rc, "R8", {60'd0, res_rc}, {60'd0, rc});
    end

    // R7 illegal function codes and opcode
    issue(rr(6'h10, 7'h01, 2, 2) | 32'd9);
    check(res_valid && res_illegal && !res_we, "R7", {63'd0, res_we}, '0);
    issue(rr(6'h11, 7'h01, 2, 2) | 32'd9);
    check(res_valid && res_illegal && !res_we, "R7", {63'd0, res_illegal}, 1);
    issue(rr(6'h12, 7'h00, 2, 2) | 32'd9);
    check(res_valid && res_illegal && !res_we, "R7", {63'd0, res_illegal}, 1);

    // R6 register 31: result write suppressed, load discarded, reads zero
    issue(rl(6'h10, 7'h20, 2, 8'd1) | 32'd31);
    check(res_valid && !res_we && res_data == 64'd2, "R6",
          {res_we, res_data}, {1'b0, 64'd2});
    load(5'd31, 64'hDEAD_BEEF);
    issue(rl(6'h10, 7'h20, 31, 8'd0) | 32'd12);
    expect_res("R6", 1'b1, 64'd0);

    // R1 register B path vs literal: B reg 31 reads zero
    issue(rr(6'h10, 7'h20, 2, 31) | 32'd12);
    expect_res("R1", 1'b1, 64'd1);

    // R9 write-back seen by following instruction
    issue(rl(6'h10, 7'h20, 2, 8'd4) | 32'd20);
    issue(rl(6'h10, 7'h20, 20, 8'd0) | 32'd23);
    expect_res("R9", 1'b1, 64'd5);

    // R9 same-cycle load and write-back to one register
    @(negedge clk);
    load_en = 1'b1; load_idx = 5'd21; load_data = 64'hAAAA_AAAA;
    issue_valid = 1'b1; issue_instr = rl(6'h10, 7'h20, 2, 8'd4) | 32'd21;
    @(negedge clk);
    load_en = 1'b0; issue_valid = 1'b0;
    issue(rl(6'h10, 7'h20, 21, 8'd0) | 32'd22);
    expect_res("R9", 1'b1, 64'd5);

    // R8 idle cycle gives no result
    @(negedge clk);
    check(!res_valid && !res_we, "R8", {63'd0, res_valid}, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule